// File: doc/BRIEF.md
# Mesh Sector Seam Substitution Stage

A lattice is divided into equal sectors, one per chip, and every chip in the mesh runs in lockstep. Each chip moves a bit-field by reading its memory word through a barrel rotator. That rotation is periodic inside the sector, so any bit that leaves one edge of the sector comes back in at the opposite edge, where it holds data from the wrong place. This block turns the local periodic shift into a true global shift. It takes the rotated word and a per-axis wrap mask. It sends the wrapped bits out to one neighbour on the outgoing lane of that axis. Each wrapped position is then overwritten with the bit that arrives on the same wire index from the opposite neighbour.

The axes are processed in a fixed order: x first, then y, then z. Each axis is one registered pipeline step. The word reaching the y step therefore already contains the x replacements, and the same holds for z. The total latency is a constant three cycles on every chip. This keeps the mesh in lockstep and lets each chip forward a lane in the same cycle as it samples its neighbour's lane.

Top module: `mesh_wrap_subst`

## Requirements
- R1: While reset is asserted and until the first accepted word, `out_valid_o` is 0, `out_data_o` is all zeros and every outgoing lane is all zeros.
- R2: A word accepted with `valid_i` high in clock cycle k appears with `out_valid_o` high after the third rising edge that follows, and at no other time.
- R3: An output bit whose index is set only in the x mask (mask slice 0, bits [W-1:0]) equals the bit with the same index on the x receive lane (slice 0) in the cycle of acceptance.
- R4: An output bit whose index is clear in all three masks equals the same bit of the accepted word.
- R5: Axes apply in the order x, y, z, on slices 0, 1 and 2. A bit set in the y mask takes the y receive lane bit one cycle after acceptance. A bit set in the z mask takes the z receive lane bit two cycles after acceptance. A later axis overrides an earlier one for that bit.
- R6: Outgoing lane a is driven combinationally in cycle k+a for a word accepted in cycle k. It carries the word as it enters axis a (after earlier axes' replacements), ANDed with mask a. Unmasked positions are 0.
- R7: An axis whose mask is all zeros leaves the word unchanged and drives its outgoing lane to all zeros.
- R8: A stage holding no valid word drives its outgoing lane to zero and ignores its receive lane. While `out_valid_o` is low, `out_data_o` keeps its last value.
- R9: Words may be accepted on consecutive cycles. Each is corrected only with the receive lanes belonging to its own stage cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Rotated word present this cycle |
| word_i | input | WORD_W | Word after the periodic barrel rotation |
| wrap_mask_i | input | NUM_AXES*WORD_W | Per-axis wrap masks, x in slice 0, y in slice 1, z in slice 2 |
| rx_lane_i | input | NUM_AXES*WORD_W | Replacement bits received from neighbours, one slice per axis |
| tx_lane_o | output | NUM_AXES*WORD_W | Wrapped local bits sent to neighbours, one slice per axis |
| out_valid_o | output | 1 | Corrected word present |
| out_data_o | output | WORD_W | Corrected word |

## Verification
The assertions assume three things. All mask slices are sampled together with the word in its acceptance cycle. Each receive lane is meaningful only in the cycle its axis stage works on that word. Every mask bit is therefore compared against a receive lane three, two or one cycles back. The stimulus drives each receive slice with the value of the word that is at that stage in that cycle. When a stage is empty, its receive slice is driven with deliberate garbage rather than kept quiet, so the stimulus never asks a stage to use data outside its own window.

// File: rtl/mws_pkg.sv
package mws_pkg;
  localparam int AXES_DEF = 3;
  localparam int WORD_DEF = 64;

  typedef enum logic [1:0] {
    AXIS_X = 2'd0,
    AXIS_Y = 2'd1,
    AXIS_Z = 2'd2
  } axis_e;
endpackage

// File: rtl/mws_rst_sync.sv
module mws_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_no = sync_q;
endmodule

// File: rtl/mws_lane_mux.sv
module mws_lane_mux #(
  parameter int W = 64
) (
  input  logic [W-1:0] local_i,
  input  logic [W-1:0] rx_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] merged_o,
  output logic [W-1:0] wrapped_o
);
  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      assign merged_o[b]  = mask_i[b] ? rx_i[b] : local_i[b];
      assign wrapped_o[b] = mask_i[b] & local_i[b];
    end
  endgenerate
endmodule

// File: rtl/mws_axis_stage.sv
module mws_axis_stage #(
  parameter int W    = 64,
  parameter int AXES = 3,
  parameter int IDX  = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [W-1:0]    data_i,
  input  logic [AXES*W-1:0] mask_i,
  input  logic [W-1:0]    rx_i,
  output logic            valid_o,
  output logic [W-1:0]    data_o,
  output logic [AXES*W-1:0] mask_o,
  output logic [W-1:0]    tx_o
);
  localparam int LO = IDX * W;

  logic [W-1:0]      own_mask;
  logic [W-1:0]      merged;
  logic [W-1:0]      wrapped;
  logic              valid_d, valid_q;
  logic [W-1:0]      data_d, data_q;
  logic [AXES*W-1:0] mask_d, mask_q;
  logic              load_en;

  assign own_mask = mask_i[LO +: W];

  mws_lane_mux #(.W(W)) u_mux (
    .local_i  (data_i),
    .rx_i     (rx_i),
    .mask_i   (own_mask),
    .merged_o (merged),
    .wrapped_o(wrapped)
  );

  assign load_en = valid_i;

  always_comb begin
    valid_d = valid_i;
    data_d  = data_q;
    mask_d  = mask_q;
    if (load_en) begin
      data_d = merged;
      mask_d = mask_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      mask_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      mask_q  <= mask_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign mask_o  = mask_q;
  assign tx_o    = valid_i ? wrapped : '0;
endmodule

// File: rtl/mesh_wrap_subst.sv
module mesh_wrap_subst #(
  parameter int WORD_W   = mws_pkg::WORD_DEF,
  parameter int NUM_AXES = mws_pkg::AXES_DEF
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [WORD_W-1:0]          word_i,
  input  logic [NUM_AXES*WORD_W-1:0] wrap_mask_i,
  input  logic [NUM_AXES*WORD_W-1:0] rx_lane_i,
  output logic [NUM_AXES*WORD_W-1:0] tx_lane_o,
  output logic                       out_valid_o,
  output logic [WORD_W-1:0]          out_data_o
);
  localparam int LANES_W = NUM_AXES * WORD_W;

  logic rst_n_q;

  mws_rst_sync u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_q)
  );

  logic               vld_ch  [NUM_AXES+1];
  logic [WORD_W-1:0]  data_ch [NUM_AXES+1];
  logic [LANES_W-1:0] mask_ch [NUM_AXES+1];

  assign vld_ch[0]  = valid_i;
  assign data_ch[0] = word_i;
  assign mask_ch[0] = wrap_mask_i;

  genvar a;
  generate
    for (a = 0; a < NUM_AXES; a++) begin : g_axis
      mws_axis_stage #(.W(WORD_W), .AXES(NUM_AXES), .IDX(a)) u_stage (
        .clk_i  (clk_i),
        .rst_ni (rst_n_q),
        .valid_i(vld_ch[a]),
        .data_i (data_ch[a]),
        .mask_i (mask_ch[a]),
        .rx_i   (rx_lane_i[a*WORD_W +: WORD_W]),
        .valid_o(vld_ch[a+1]),
        .data_o (data_ch[a+1]),
        .mask_o (mask_ch[a+1]),
        .tx_o   (tx_lane_o[a*WORD_W +: WORD_W])
      );
    end
  endgenerate

  assign out_valid_o = vld_ch[NUM_AXES];
  assign out_data_o  = data_ch[NUM_AXES];
endmodule

// File: rtl/mesh_wrap_subst_chk.sv
module mesh_wrap_subst_chk #(
  parameter int W    = 64,
  parameter int AXES = 3
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              valid_i,
  input logic [W-1:0]      word_i,
  input logic [AXES*W-1:0] wrap_mask_i,
  input logic [AXES*W-1:0] rx_lane_i,
  input logic [AXES*W-1:0] tx_lane_o,
  input logic              out_valid_o,
  input logic [W-1:0]      out_data_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  wire [W-1:0] m_x  = wrap_mask_i[0 +: W];
  wire [W-1:0] m_y  = wrap_mask_i[W +: W];
  wire [W-1:0] m_z  = wrap_mask_i[2*W +: W];
  wire [W-1:0] rx_x = rx_lane_i[0 +: W];
  wire [W-1:0] rx_z = rx_lane_i[2*W +: W];
  wire [W-1:0] tx_x = tx_lane_o[0 +: W];
  wire         full = (age_q == 2'd3);

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    full |-> (out_valid_o == $past(valid_i, 3)));

  p_xsub_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (full && out_valid_o) |->
      (((out_data_o ^ $past(rx_x, 3)) & $past(m_x, 3) & ~$past(m_y, 3) & ~$past(m_z, 3)) == '0));

  p_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (full && out_valid_o) |->
      (((out_data_o ^ $past(word_i, 3)) & ~($past(m_x, 3) | $past(m_y, 3) | $past(m_z, 3))) == '0));

  p_zlast_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (full && out_valid_o) |->
      (((out_data_o ^ $past(rx_z, 1)) & $past(m_z, 3)) == '0));

  p_txmask_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tx_x & ~m_x) == '0);

  p_txidle_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !valid_i |-> (tx_x == '0));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (age_q != 2'd0 && !out_valid_o) |-> $stable(out_data_o));
endmodule

bind mesh_wrap_subst mesh_wrap_subst_chk #(.W(WORD_W), .AXES(NUM_AXES)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n_q),
  .valid_i    (valid_i),
  .word_i     (word_i),
  .wrap_mask_i(wrap_mask_i),
  .rx_lane_i  (rx_lane_i),
  .tx_lane_o  (tx_lane_o),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o)
);

// File: tb/mesh_wrap_subst_bench.sv
module mesh_wrap_subst_bench;
  localparam int W  = 64;
  localparam int AX = 3;
  localparam int MAXN = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic            valid_i;
  logic [W-1:0]    word_i;
  logic [AX*W-1:0] wrap_mask_i;
  logic [AX*W-1:0] rx_lane_i;
  logic [AX*W-1:0] tx_lane_o;
  logic            out_valid_o;
  logic [W-1:0]    out_data_o;

  always #10 clk_i = ~clk_i;

  mesh_wrap_subst u_mesh_wrap_subst (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .word_i(word_i),
    .wrap_mask_i(wrap_mask_i), .rx_lane_i(rx_lane_i), .tx_lane_o(tx_lane_o),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [W-1:0] s_word [MAXN];
  logic [W-1:0] s_mask [MAXN][AX];
  logic [W-1:0] s_rx   [MAXN][AX];
  logic [W-1:0] s_stw  [MAXN][AX+1];
  bit           s_v    [MAXN];
  int           s_n;
  logic [W-1:0] last_out = '0;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int s);
    logic [31:0] a, b;
    a = 32'(s) * 32'h9E37_79B9 + 32'h0F0F_1234;
    b = (32'(s) * 32'h85EB_CA6B) ^ 32'h5A5A_C3C3;
    return {a, b};
  endfunction

  task automatic clear_set();
    for (int i = 0; i < MAXN; i++) begin
      s_v[i] = 1'b0; s_word[i] = '0;
      for (int a = 0; a < AX; a++) begin s_mask[i][a] = '0; s_rx[i][a] = '0; end
    end
  endtask

  // model: axes applied in order, each replacing masked bits by its lane
  task automatic prepare();
    for (int i = 0; i < s_n; i++) begin
      s_stw[i][0] = s_word[i];
      for (int a = 0; a < AX; a++)
        s_stw[i][a+1] = (s_stw[i][a] & ~s_mask[i][a]) | (s_rx[i][a] & s_mask[i][a]);
    end
  endtask

  task automatic run(input string tag);
    prepare();
    for (int j = 0; j < s_n + AX + 1; j++) begin
      @(negedge clk_i);
      valid_i = (j < s_n) ? s_v[j] : 1'b0;
      word_i  = (j < s_n) ? s_word[j] : pat(j + 900);
      for (int a = 0; a < AX; a++) begin
        int k = j - a;
        wrap_mask_i[a*W +: W] = (j < s_n) ? s_mask[j][a] : '0;
        if (k >= 0 && k < s_n && s_v[k]) rx_lane_i[a*W +: W] = s_rx[k][a];
        else                             rx_lane_i[a*W +: W] = pat(j * 7 + a + 500);
      end
      #1;
      for (int a = 0; a < AX; a++) begin
        int k = j - a;
        logic [W-1:0] et;
        et = (k >= 0 && k < s_n && s_v[k]) ? (s_stw[k][a] & s_mask[k][a]) : '0;
        chk(tx_lane_o[a*W +: W] == et, {tag, " R6 tx lane"}, tx_lane_o[a*W +: W], et);
      end
      begin
        int  k = j - AX;
        bit  ev;
        ev = (k >= 0 && k < s_n && s_v[k]);
        chk(out_valid_o == ev, {tag, " R2 out valid"}, W'(out_valid_o), W'(ev));
        if (ev) begin
          last_out = s_stw[k][AX];
          chk(out_data_o == last_out, {tag, " data"}, out_data_o, last_out);
        end else begin
          chk(out_data_o == last_out, {tag, " R8 hold"}, out_data_o, last_out);
        end
      end
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; valid_i = 1'b0; word_i = pat(1);
    wrap_mask_i = '1; rx_lane_i = {pat(2), pat(3), pat(4)};
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1 valid in reset", W'(out_valid_o), '0);
    chk(out_data_o == '0, "R1 data in reset", out_data_o, '0);
    chk(tx_lane_o == '0, "R1 lanes in reset", tx_lane_o[W-1:0], '0);
    rst_ni = 1'b1; wrap_mask_i = '0;
    repeat (4) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1 valid after release", W'(out_valid_o), '0);
    chk(tx_lane_o == '0, "R1 lanes after release", tx_lane_o[W-1:0], '0);
  endtask

  task automatic t_x_only();
    clear_set(); s_n = 1; s_v[0] = 1'b1;
    s_word[0] = pat(10); s_mask[0][0] = 64'h8000_0000_0000_00FF;
    s_rx[0][0] = pat(11); s_rx[0][1] = pat(12); s_rx[0][2] = pat(13);
    run("R3 R4 x-only");
  endtask

  task automatic t_order();
    clear_set(); s_n = 1; s_v[0] = 1'b1;
    s_word[0] = pat(20);
    s_mask[0][0] = 64'h0000_FFFF_0000_FFFF;
    s_mask[0][1] = 64'h0000_00FF_00FF_00FF;
    s_mask[0][2] = 64'h0000_000F_000F_F000;
    s_rx[0][0] = pat(21); s_rx[0][1] = pat(22); s_rx[0][2] = pat(23);
    run("R5 ordering");
  endtask

  task automatic t_zero_axis();
    clear_set(); s_n = 1; s_v[0] = 1'b1;
    s_word[0] = pat(30);
    s_mask[0][0] = 64'hF0F0_0000_0000_0000;
    s_mask[0][2] = 64'h0000_0000_0000_0F0F;
    s_rx[0][0] = pat(31); s_rx[0][1] = '1; s_rx[0][2] = pat(33);
    run("R7 zero y axis");
    clear_set(); s_n = 1; s_v[0] = 1'b1;
    s_word[0] = pat(34); s_rx[0][0] = '1; s_rx[0][1] = '1; s_rx[0][2] = '1;
    run("R7 R4 all axes zero");
  endtask

  task automatic t_stream();
    clear_set(); s_n = 6;
    for (int i = 0; i < 6; i++) begin
      s_v[i] = 1'b1; s_word[i] = pat(40 + i);
      for (int a = 0; a < AX; a++) begin
        s_mask[i][a] = pat(60 + i * 3 + a) & pat(80 + i + a);
        s_rx[i][a]   = pat(100 + i * 3 + a);
      end
    end
    run("R9 back-to-back");
  endtask

  task automatic t_bubbles();
    clear_set(); s_n = 7;
    for (int i = 0; i < 7; i++) begin
      s_v[i] = (i % 3) != 1; s_word[i] = pat(200 + i);
      for (int a = 0; a < AX; a++) begin
        s_mask[i][a] = pat(220 + i + a * 5);
        s_rx[i][a]   = pat(240 + i * 3 + a);
      end
    end
    run("R8 R9 bubbles");
    for (int j = 0; j < 4; j++) begin
      @(negedge clk_i);
      valid_i = 1'b0; word_i = pat(300 + j);
      wrap_mask_i = {pat(301), pat(302), pat(303)};
      rx_lane_i = {pat(304 + j), pat(305), pat(306)};
      #1;
      chk(tx_lane_o[W-1:0] == '0, "R8 idle x lane", tx_lane_o[W-1:0], '0);
      chk(out_valid_o == 1'b0, "R8 idle valid", W'(out_valid_o), '0);
      chk(out_data_o == last_out, "R8 idle hold", out_data_o, last_out);
    end
    wrap_mask_i = '0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_x_only();
    t_order();
    t_zero_axis();
    t_stream();
    t_bubbles();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule